// File: doc/BRIEF.md
# Legacy Parallel Port Register Block

This block sits on a host register bus and presents the eight byte registers of a PC-style parallel port: the output data latch, the pin status byte, the control byte and two plain storage bytes for the enhanced-protocol address and data phases. Only the low three bus address bits select a register; any higher bits the bus carries are left to an outside window decoder. Reads and writes are single-cycle byte strobes, and read data appears on `bus_rdata` one clock after the read strobe, where it stays until the next read.

Toward the port the block drives an output data byte with a one-cycle write pulse, and a control byte with a one-cycle update pulse that fires only when the control value really changes. It samples the pin data bus and the pin status byte at the moment the host reads them. An acknowledge event from the port can raise a level interrupt toward the host when the control byte enables it; reading the status register clears it.

Control byte bits: 0 strobe, 1 auto-linefeed, 2 init, 3 select, 4 interrupt enable, 5 bidirectional enable, 7:6 reserved and always read as one. On the status pins, bit 2 carries the interrupt flag, bit 1 is reserved and bit 0 is the enhanced-protocol timeout flag; the block passes the byte through as sampled.

Top module: `pport_regfile`

## Requirements
- R1: After reset `pin_dout`, `bus_rdata` and `irq` are zero, `pin_ctl` equals the CTL_RST parameter (default 0xCC), and `dout_wr` and `ctl_upd` are low.
- R2: A write to offset 0 places the byte on `pin_dout` and raises `dout_wr` for exactly one cycle, both in the cycle after the write strobe.
- R3: With control bit 5 clear, a read of offset 0 returns the latched output byte and ignores `pin_din`.
- R4: With control bit 5 set, a read of offset 0 returns `pin_din` and loads that byte into the data latch, so `pin_dout` and later reads with bit 5 clear show it.
- R5: A read of offset 1 returns `pin_status` as sampled in the strobe cycle and leaves `irq` low afterwards unless R10 applies.
- R6: A write to offset 2 stores the byte with bits 7 and 6 forced to one; `pin_ctl` and reads of offset 2 show that forced value.
- R7: `ctl_upd` pulses for one cycle, together with the new `pin_ctl`, only when the forced value differs from the current control byte; rewriting the same value gives no pulse.
- R8: Offsets 3 and 4 are independent read/write storage bytes, zero after reset.
- R9: `ack_evt` sets `irq` in the following cycle only when control bit 4 is set; with bit 4 clear the event has no effect.
- R10: When `ack_evt` (enabled) and a status read fall in the same cycle, the event wins and `irq` is high afterwards.
- R11: Reads of offsets 5, 6 and 7 return 0xFF and writes to them change no output and no register.
- R12: Address bits above bit 2 are ignored: an address aliases the offset given by its low three bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address; low three bits select the offset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| pin_din | input | 8 | Data bus sampled from the port |
| pin_status | input | 8 | Status byte sampled from the port |
| pin_dout | output | 8 | Output data latch toward the port |
| dout_wr | output | 1 | One-cycle pulse per data write |
| pin_ctl | output | 8 | Control byte toward the port |
| ctl_upd | output | 1 | One-cycle pulse when the control byte changes |
| ack_evt | input | 1 | Acknowledge event from the port |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench aims at the control change filter: a write of the same value, and a write that differs only in the two forced bits, must not pulse `ctl_upd`, so a design that compares the raw byte or forwards every write is caught. It flips the direction bit between reads of offset 0 with distinct values on the latch and on `pin_din`, exposing a design that always reads one side or fails to reload the latch. It fires the acknowledge event with the enable clear, and together with a status read, so a design that ignores the enable or lets the clear win drops or invents an interrupt. Writes to the empty offsets and aliased upper addresses check that decode uses exactly the low three bits.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 3;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [OFS_W-1:0]  ofs_t;

  // Register offsets inside the eight-byte window
  localparam ofs_t OFS_DATA = 3'd0;
  localparam ofs_t OFS_STAT = 3'd1;
  localparam ofs_t OFS_CTRL = 3'd2;
  localparam ofs_t OFS_EADR = 3'd3;
  localparam int   EPP_REGS = 2;  // offsets 3 and 4

  // Control bit positions the block itself decodes
  localparam int CTL_IRQEN = 4;
  localparam int CTL_BIDIR = 5;

  localparam byte_t CTL_FORCE = 8'hC0;
  localparam byte_t OPEN_READ = 8'hFF;
endpackage

// File: rtl/pport_byte_reg.sv
module pport_byte_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (ld) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/pport_ctl_reg.sv
module pport_ctl_reg
  import pport_pkg::*;
#(
  parameter byte_t RST   = 8'hCC,
  parameter byte_t FORCE = CTL_FORCE
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_hit,
  input  byte_t wdata,
  output byte_t ctl_q,
  output logic  upd_q
);
  byte_t cand;
  byte_t ctl_nxt;
  logic  chg;

  always_comb begin
    cand    = wdata | FORCE;
    chg     = wr_hit && (cand != ctl_q);
    ctl_nxt = chg ? cand : ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= RST | FORCE;
      upd_q <= 1'b0;
    end else begin
      ctl_q <= ctl_nxt;
      upd_q <= chg;
    end
  end
endmodule

// File: rtl/pport_irq.sv
module pport_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic en,
  input  logic clr,
  output logic irq_q
);
  logic irq_nxt;

  // A qualified event has priority over a clearing status read
  always_comb begin
    irq_nxt = irq_q;
    if (clr)        irq_nxt = 1'b0;
    if (evt && en)  irq_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_nxt;
  end
endmodule

// File: rtl/pport_regfile.sv
module pport_regfile
  import pport_pkg::*;
#(
  parameter int    ADDR_W   = 4,
  parameter byte_t CTL_RST  = 8'hCC,
  parameter byte_t DATA_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        pin_din,
  input  logic [7:0]        pin_status,
  output logic [7:0]        pin_dout,
  output logic              dout_wr,
  output logic [7:0]        pin_ctl,
  output logic              ctl_upd,
  input  logic              ack_evt,
  output logic              irq
);
  ofs_t  ofs;
  logic  wr_data, wr_ctl, rd_data, rd_stat;
  logic  bidir;
  byte_t data_q, data_nxt;
  logic  dout_wr_nxt;
  byte_t rd_mux, rdata_q, rdata_nxt;
  byte_t epp_q [EPP_REGS];

  assign ofs = bus_addr[OFS_W-1:0];

  generate
    if (ADDR_W > OFS_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^bus_addr[ADDR_W-1:OFS_W];
    end
  endgenerate

  assign wr_data = bus_wr && (ofs == OFS_DATA);
  assign wr_ctl  = bus_wr && (ofs == OFS_CTRL);
  assign rd_data = bus_rd && (ofs == OFS_DATA);
  assign rd_stat = bus_rd && (ofs == OFS_STAT);

  // Control register with change filter
  pport_ctl_reg #(.RST(CTL_RST), .FORCE(CTL_FORCE)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_ctl),
    .wdata  (bus_wdata),
    .ctl_q  (pin_ctl),
    .upd_q  (ctl_upd)
  );

  assign bidir = pin_ctl[CTL_BIDIR];

  // Storage bytes at consecutive offsets
  generate
    for (genvar k = 0; k < EPP_REGS; k++) begin : g_epp
      logic ld_k;
      assign ld_k = bus_wr && (ofs == OFS_EADR + ofs_t'(k));
      pport_byte_reg #(.W(BYTE_W), .RST('0)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld_k),
        .d     (bus_wdata),
        .q     (epp_q[k])
      );
    end
  endgenerate

  // Interrupt flag
  pport_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (ack_evt),
    .en    (pin_ctl[CTL_IRQEN]),
    .clr   (rd_stat),
    .irq_q (irq)
  );

  // Data latch: host write, or reload from pins on a bidirectional read
  always_comb begin
    data_nxt    = data_q;
    dout_wr_nxt = 1'b0;
    if (wr_data) begin
      data_nxt    = bus_wdata;
      dout_wr_nxt = 1'b1;
    end else if (rd_data && bidir) begin
      data_nxt = pin_din;
    end
  end

  // Read multiplexer
  always_comb begin
    unique case (ofs)
      3'd0:    rd_mux = bidir ? pin_din : data_q;
      3'd1:    rd_mux = pin_status;
      3'd2:    rd_mux = pin_ctl;
      3'd3:    rd_mux = epp_q[0];
      3'd4:    rd_mux = epp_q[1];
      default: rd_mux = OPEN_READ;
    endcase
    rdata_nxt = bus_rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= DATA_RST;
      dout_wr <= 1'b0;
      rdata_q <= '0;
    end else begin
      data_q  <= data_nxt;
      dout_wr <= dout_wr_nxt;
      rdata_q <= rdata_nxt;
    end
  end

  assign pin_dout  = data_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/pport_regfile_chk.sv
module pport_regfile_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        pin_dout,
  input logic              dout_wr,
  input logic [7:0]        pin_ctl,
  input logic              ctl_upd,
  input logic              ack_evt,
  input logic              irq
);
  p_ctl_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ctl[7:6] == 2'b11);

  p_upd_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_upd |-> !$stable(pin_ctl));

  p_no_upd_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_upd |-> $stable(pin_ctl));

  p_dout_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[2:0] == 3'd0) |=> (dout_wr && pin_dout == $past(bus_wdata)));

  p_irq_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[2:0] == 3'd1 && !ack_evt) |=> !irq);

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(ack_evt && pin_ctl[4])) |=> !irq);

  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && pin_ctl[4]) |=> irq);

  p_open_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[2:0] >= 3'd5) |=> bus_rdata == 8'hFF);
endmodule

bind pport_regfile pport_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_dout  (pin_dout),
  .dout_wr   (dout_wr),
  .pin_ctl   (pin_ctl),
  .ctl_upd   (ctl_upd),
  .ack_evt   (ack_evt),
  .irq       (irq)
);

// File: tb/tb_pport_regfile.sv
module tb_pport_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;

  logic clk, rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic bus_wr, bus_rd, ack_evt;
  logic [7:0] bus_wdata, bus_rdata, pin_din, pin_status, pin_dout, pin_ctl;
  logic dout_wr, ctl_upd, irq;

  pport_regfile #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_din(pin_din),
    .pin_status(pin_status), .pin_dout(pin_dout), .dout_wr(dout_wr),
    .pin_ctl(pin_ctl), .ctl_upd(ctl_upd), .ack_evt(ack_evt), .irq(irq)
  );

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];
  int n_chk = 0, n_fail = 0;
  logic pend;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: one read result per read strobe, one cycle later
  always @(posedge clk) pend <= rst_n && bus_rd;
  always @(negedge clk) begin
    if (pend) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard: actual %h expected none", bus_rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        chk(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, logic [7:0] exp, string tag, bit evt = 1'b0);
    item_t it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    bus_addr = a; bus_rd = 1'b1; ack_evt = evt;
    @(negedge clk);
    bus_rd = 1'b0; ack_evt = 1'b0;
  endtask

  task automatic pulse_evt();
    @(negedge clk);
    ack_evt = 1'b1;
    @(negedge clk);
    ack_evt = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    pin_din = 0; pin_status = 0; ack_evt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin_dout", pin_dout, 8'h00);
    chk("R1 pin_ctl", pin_ctl, 8'hCC);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 bus_rdata", bus_rdata, 8'h00);
    chk("R1 pulses", {6'd0, dout_wr, ctl_upd}, 8'h00);
    rd(4'd2, 8'hCC, "R6 ctl reset readback");

    // R6 / R7 control writes
    wr(4'd2, 8'h05);
    chk("R7 upd on change", {7'd0, ctl_upd}, 8'h01);
    chk("R6 forced ctl", pin_ctl, 8'hC5);
    rd(4'd2, 8'hC5, "R6 ctl readback");
    wr(4'd2, 8'h05);
    chk("R7 no upd same value", {7'd0, ctl_upd}, 8'h00);
    wr(4'd2, 8'hC5);
    chk("R7 no upd forced equal", {7'd0, ctl_upd}, 8'h00);
    chk("R7 ctl unchanged", pin_ctl, 8'hC5);

    // R2 data write
    wr(4'd0, 8'h5A);
    chk("R2 pin_dout", pin_dout, 8'h5A);
    chk("R2 dout_wr", {7'd0, dout_wr}, 8'h01);
    @(negedge clk);
    chk("R2 dout_wr one cycle", {7'd0, dout_wr}, 8'h00);

    // R3 / R4 direction
    pin_din = 8'h3C;
    rd(4'd0, 8'h5A, "R3 latched read");
    wr(4'd2, 8'h20);
    chk("R4 ctl bidir", pin_ctl, 8'hE0);
    rd(4'd0, 8'h3C, "R4 pin read");
    chk("R4 latch reloaded", pin_dout, 8'h3C);
    pin_din = 8'h99;
    wr(4'd2, 8'h00);
    rd(4'd0, 8'h3C, "R4 reloaded latch read");

    // R8 storage
    wr(4'd3, 8'h11);
    wr(4'd4, 8'h22);
    rd(4'd3, 8'h11, "R8 offset 3");
    rd(4'd4, 8'h22, "R8 offset 4");

    // R9 / R5 interrupt
    pulse_evt();
    chk("R9 event ignored", {7'd0, irq}, 8'h00);
    wr(4'd2, 8'h10);
    pulse_evt();
    chk("R9 event sets irq", {7'd0, irq}, 8'h01);
    pin_status = 8'h7B;
    rd(4'd1, 8'h7B, "R5 status read");
    chk("R5 irq cleared", {7'd0, irq}, 8'h00);

    // R10 event and status read together
    pin_status = 8'h84;
    rd(4'd1, 8'h84, "R10 status value", 1'b1);
    chk("R10 event wins", {7'd0, irq}, 8'h01);
    rd(4'd1, 8'h84, "R10 second status");
    chk("R10 later clear", {7'd0, irq}, 8'h00);

    // R11 open offsets
    rd(4'd5, 8'hFF, "R11 offset 5");
    rd(4'd6, 8'hFF, "R11 offset 6");
    rd(4'd7, 8'hFF, "R11 offset 7");
    wr(4'd5, 8'h00);
    wr(4'd6, 8'h00);
    wr(4'd7, 8'h00);
    chk("R11 ctl untouched", pin_ctl, 8'hD0);
    chk("R11 dout untouched", pin_dout, 8'h3C);
    chk("R11 no pulses", {6'd0, dout_wr, ctl_upd}, 8'h00);
    rd(4'd3, 8'h11, "R11 offset 3 untouched");
    rd(4'd4, 8'h22, "R11 offset 4 untouched");
    rd(4'd5, 8'hFF, "R11 offset 5 after write");

    // R12 aliasing
    wr(4'hA, 8'h01);
    chk("R12 alias write ctl", pin_ctl, 8'hC1);
    rd(4'hB, 8'h11, "R12 alias read offset 3");
    rd(4'h8, 8'h3C, "R12 alias read data");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule